// File: doc/BRIEF.md
# Rounding Serial Output Formatter

This block sits behind a filter accumulator. Each time the accumulator presents a wide signed result, the block keeps the upper bits of that result at a programmed output width. It either drops the lower bits (truncation) or first adds half of the new least significant step (rounding). When rounding pushes a positive value past the largest value the output width can hold, the word saturates. The reduced word is then shifted out one bit at a time. An output clock and a word sync pulse go with the data, so an external receiver can frame and capture it.

The output width, rounding choice, bit order and output clock enable are sampled together with the result, so each word carries its own settings. One reduced word can wait in a holding slot while another word is being shifted out. The held word starts on the cycle after the current word ends, with no gap between them.

Top module: `ofmt_top`

## Requirements
- R1: With cfg_round low, the transmitted word equals acc_data as a signed number divided by 2^(ACC_W-w) and rounded toward minus infinity, sent as w bits of two's complement, where w is the effective width.
- R2: With cfg_round high, 2^(ACC_W-w-1) is added to acc_data before the lower ACC_W-w bits are dropped.
- R3: When rounding gives a value above 2^(w-1)-1, the transmitted word is 2^(w-1)-1.
- R4: The effective width w is cfg_width when cfg_width lies from 2 to OUT_MAX. Any other cfg_width value gives w = OUT_MAX.
- R5: With cfg_msb_first = 1, bits leave from the sign bit down to bit 0. With cfg_msb_first = 0, they leave from bit 0 upward.
- R6: Each bit holds ser_data for two clk cycles. ser_clk is low in the first cycle and high in the second, so a receiver samples on the rising edge of ser_clk. ser_sync is high during both cycles of the first bit of a word and low at all other times.
- R7: ser_clk stays low while no word is being sent. It also stays low for a whole word whose cfg_clk_en was 0 when the word was accepted. ser_sync and ser_data are still produced for that word.
- R8: The configuration inputs are sampled on the clk edge that sees acc_valid high. ser_sync rises on the next clk edge after that when the shifter is idle. A result accepted during a transmission is held, and its first bit follows the last bit of the current word directly.
- R9: If a second result arrives while one is already held, the newer result replaces the held one, and the older one is never sent.
- R10: While rst_n is low, ser_data, ser_clk and ser_sync are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | acc_data carries a new result |
| acc_data | input | ACC_W | Signed accumulator result |
| cfg_width | input | WW | Requested output word width |
| cfg_round | input | 1 | 1 = round, 0 = truncate |
| cfg_msb_first | input | 1 | 1 = send most significant bit first |
| cfg_clk_en | input | 1 | 1 = drive ser_clk during the word |
| ser_data | output | 1 | Serial data bit |
| ser_clk | output | 1 | Gated output clock |
| ser_sync | output | 1 | Word start marker |

## Verification
A wrong bit index or a wrong phase bit in the shifter shows up in the first bit period after a load: sync lasts the wrong length, or the clock pulse lands at the wrong place. A wrong reduction shows up as a wrong decoded word once that word has been shifted out, which takes at most 2*OUT_MAX cycles. An error in the holding slot appears as a word that is missing, repeated or out of order, or as a gap between words sent back to back. Each of these becomes visible within two word periods of the result that caused it.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} ofmt_phase_t;
  typedef enum logic {ORD_LSB = 1'b0, ORD_MSB = 1'b1} ofmt_order_t;
endpackage

// File: rtl/ofmt_reduce.sv
module ofmt_reduce #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  localparam int WW   = $clog2(OUT_W + 1)
) (
  input  logic [IN_W-1:0]  acc,
  input  logic [WW-1:0]    width,
  input  logic             rnd,
  output logic [OUT_W-1:0] word,
  output logic [WW-1:0]    eff_w,
  output logic             sat
);
  // Keep the upper w bits, optionally adding half a step first, and clip
  // the positive side when rounding overflows.
  function automatic logic [OUT_W-1:0] shrink(input logic signed [IN_W-1:0] a,
                                              input int unsigned w,
                                              input logic r,
                                              output logic s);
    logic signed [IN_W:0] e;
    logic signed [IN_W:0] q;
    logic signed [IN_W:0] lim;
    int unsigned sh;
    sh  = IN_W - w;
    e   = {a[IN_W-1], a};
    if (r) e = e + ((IN_W+1)'(1) << (sh - 1));
    q   = e >>> sh;
    lim = ((IN_W+1)'(1) << (w - 1)) - (IN_W+1)'(1);
    s   = (q > lim);
    return s ? lim[OUT_W-1:0] : q[OUT_W-1:0];
  endfunction

  always_comb begin
    eff_w = ((width < WW'(2)) || (width > WW'(OUT_W))) ? WW'(OUT_W) : width;
    word  = shrink(acc, int'(eff_w), rnd, sat);
  end
endmodule

// File: rtl/ofmt_hold.sv
module ofmt_hold #(
  parameter int OUT_W = 16,
  localparam int WW   = $clog2(OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OUT_W-1:0] in_word,
  input  logic [WW-1:0]    in_w,
  input  logic             in_msb,
  input  logic             in_cken,
  input  logic             take,
  output logic             pend_v,
  output logic [OUT_W-1:0] pend_word,
  output logic [WW-1:0]    pend_w,
  output logic             pend_msb,
  output logic             pend_cken
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_word <= '0;
      pend_w    <= WW'(OUT_W);
      pend_msb  <= 1'b0;
      pend_cken <= 1'b0;
    end else if (in_valid) begin
      pend_v    <= 1'b1;
      pend_word <= in_word;
      pend_w    <= in_w;
      pend_msb  <= in_msb;
      pend_cken <= in_cken;
    end else if (take) begin
      pend_v    <= 1'b0;
    end
  end
endmodule

// File: rtl/ofmt_serial.sv
module ofmt_serial
  import ofmt_pkg::*;
#(
  parameter int OUT_W = 16,
  localparam int WW   = $clog2(OUT_W + 1),
  localparam int IW   = $clog2(OUT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_v,
  input  logic [OUT_W-1:0] pend_word,
  input  logic [WW-1:0]    pend_w,
  input  logic             pend_msb,
  input  logic             pend_cken,
  output logic             take,
  output logic             busy,
  output logic             tx_clk_en,
  output logic             sdat,
  output logic             sclk,
  output logic             sync
);
  logic             busy_q;
  ofmt_phase_t      ph_q;
  logic [WW-1:0]    idx_q;
  logic [OUT_W-1:0] word_q;
  logic [WW-1:0]    w_q;
  ofmt_order_t      ord_q;
  logic             cken_q;
  logic             last;
  logic [WW-1:0]    sel;

  assign last = busy_q && (ph_q == PH_HIGH) && (idx_q == w_q - WW'(1));
  assign take = pend_v && (!busy_q || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_LOW;
      idx_q  <= '0;
      word_q <= '0;
      w_q    <= WW'(OUT_W);
      ord_q  <= ORD_LSB;
      cken_q <= 1'b0;
    end else if (take) begin
      busy_q <= 1'b1;
      ph_q   <= PH_LOW;
      idx_q  <= '0;
      word_q <= pend_word;
      w_q    <= pend_w;
      ord_q  <= ofmt_order_t'(pend_msb);
      cken_q <= pend_cken;
    end else if (busy_q) begin
      if (ph_q == PH_LOW) begin
        ph_q <= PH_HIGH;
      end else begin
        ph_q <= PH_LOW;
        if (last) busy_q <= 1'b0;
        else      idx_q  <= idx_q + WW'(1);
      end
    end
  end

  assign sel       = (ord_q == ORD_MSB) ? (w_q - WW'(1) - idx_q) : idx_q;
  assign busy      = busy_q;
  assign tx_clk_en = busy_q && cken_q;
  assign sdat      = busy_q && word_q[sel[IW-1:0]];
  assign sclk      = tx_clk_en && (ph_q == PH_HIGH);
  assign sync      = busy_q && (idx_q == '0);
endmodule

// File: rtl/ofmt_top.sv
module ofmt_top #(
  parameter int ACC_W   = 24,
  parameter int OUT_MAX = 16,
  localparam int WW     = $clog2(OUT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [ACC_W-1:0] acc_data,
  input  logic [WW-1:0]    cfg_width,
  input  logic             cfg_round,
  input  logic             cfg_msb_first,
  input  logic             cfg_clk_en,
  output logic             ser_data,
  output logic             ser_clk,
  output logic             ser_sync
);
  logic [OUT_MAX-1:0] red_word;
  logic [WW-1:0]      red_w;
  logic               red_sat;
  logic               pend_v;
  logic [OUT_MAX-1:0] pend_word;
  logic [WW-1:0]      pend_w;
  logic               pend_msb;
  logic               pend_cken;
  logic               take;
  logic               busy;
  logic               tx_clk_en;

  ofmt_reduce #(.IN_W(ACC_W), .OUT_W(OUT_MAX)) u_red (
    .acc(acc_data), .width(cfg_width), .rnd(cfg_round),
    .word(red_word), .eff_w(red_w), .sat(red_sat)
  );

  ofmt_hold #(.OUT_W(OUT_MAX)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(acc_valid), .in_word(red_word),
    .in_w(red_w), .in_msb(cfg_msb_first), .in_cken(cfg_clk_en), .take(take),
    .pend_v(pend_v), .pend_word(pend_word), .pend_w(pend_w),
    .pend_msb(pend_msb), .pend_cken(pend_cken)
  );

  ofmt_serial #(.OUT_W(OUT_MAX)) u_ser (
    .clk(clk), .rst_n(rst_n), .pend_v(pend_v), .pend_word(pend_word),
    .pend_w(pend_w), .pend_msb(pend_msb), .pend_cken(pend_cken),
    .take(take), .busy(busy), .tx_clk_en(tx_clk_en),
    .sdat(ser_data), .sclk(ser_clk), .sync(ser_sync)
  );
endmodule

// File: rtl/ofmt_chk.sv
module ofmt_chk #(
  parameter int OUT_MAX = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               ser_clk,
  input logic               ser_sync,
  input logic               busy,
  input logic               tx_clk_en,
  input logic               take,
  input logic               pend_v,
  input logic [OUT_MAX-1:0] pend_word
);
  AST_SYNC_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_sync) |=> ser_sync); // R6
  AST_SYNC_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sync && $past(ser_sync)) |=> !ser_sync); // R6
  AST_CLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |=> !ser_clk); // R6
  AST_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_clk); // R7
  AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_clk_en) |-> !ser_clk); // R7
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ser_sync); // R8
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !acc_valid && !take) |=> (pend_v && $stable(pend_word))); // R8
endmodule

bind ofmt_top ofmt_chk #(.OUT_MAX(OUT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .ser_clk(ser_clk),
  .ser_sync(ser_sync), .busy(busy), .tx_clk_en(tx_clk_en), .take(take),
  .pend_v(pend_v), .pend_word(pend_word)
);

// File: tb/sim_ofmt_top.sv
module sim_ofmt_top;
  localparam int CLK_P = 10;
  localparam int AW    = 24;
  localparam int OM    = 16;
  localparam int WW    = $clog2(OM + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_data = '0;
  logic [WW-1:0] cfg_width = '0;
  logic          cfg_round = 1'b0;
  logic          cfg_msb_first = 1'b0;
  logic          cfg_clk_en = 1'b0;
  logic          ser_data, ser_clk, ser_sync;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic clk_prev = 1'b0;
  logic sync_prev = 1'b0;
  logic rx_bit[$];
  logic rx_syn[$];
  int   sync_at[$];

  always #(CLK_P/2) clk = ~clk;

  ofmt_top #(.ACC_W(AW), .OUT_MAX(OM)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_data(acc_data),
    .cfg_width(cfg_width), .cfg_round(cfg_round), .cfg_msb_first(cfg_msb_first),
    .cfg_clk_en(cfg_clk_en), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_sync(ser_sync)
  );

  // Receiver model: capture on each rising edge of ser_clk.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (ser_clk && !clk_prev) begin
        rx_bit.push_back(ser_data);
        rx_syn.push_back(ser_sync);
      end
      if (ser_sync && !sync_prev) sync_at.push_back(cyc);
    end
    clk_prev  = ser_clk;
    sync_prev = ser_sync;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int w);
    return (w < 2 || w > OM) ? OM : w;
  endfunction

  function automatic int floor_div(input int a, input int b);
    int q;
    q = a / b;
    if ((a % b) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  function automatic int exp_val(input logic [AW-1:0] d, input int wr, input bit rnd);
    int v, w, div, q, mx;
    w   = eff(wr);
    v   = int'($signed(d));
    div = 1 << (AW - w);
    if (rnd) v = v + div / 2;
    q   = floor_div(v, div);
    mx  = (1 << (w - 1)) - 1;
    return (q > mx) ? mx : q;
  endfunction

  task automatic clear_rx();
    rx_bit.delete(); rx_syn.delete(); sync_at.delete();
  endtask

  task automatic send(input logic [AW-1:0] d, input int w, input bit rnd,
                      input bit msb, input bit cken);
    acc_valid = 1'b1; acc_data = d; cfg_width = WW'(w);
    cfg_round = rnd; cfg_msb_first = msb; cfg_clk_en = cken;
    @(negedge clk);
    acc_valid = 1'b0; acc_data = '0; cfg_width = '0;
    cfg_round = 1'b0; cfg_msb_first = 1'b0; cfg_clk_en = 1'b0;
  endtask

  task automatic get_word(input string tag, input int wr, input bit msb, input int exp);
    int w, val, guard;
    logic [OM-1:0] raw;
    w = eff(wr);
    guard = 0;
    while (rx_bit.size() < w && guard < 4 * OM + 20) begin
      @(negedge clk); guard++;
    end
    if (rx_bit.size() < w) begin
      chk({tag, " bits received"}, rx_bit.size(), w);
      return;
    end
    raw = '0;
    for (int i = 0; i < w; i++) begin
      logic b, s;
      b = rx_bit.pop_front();
      s = rx_syn.pop_front();
      chk({tag, " sync on bit"}, int'(s), (i == 0) ? 1 : 0);
      raw[msb ? (w - 1 - i) : i] = b;
    end
    val = int'(raw);
    if (raw[w-1]) val = val - (1 << w);
    chk(tag, val, exp);
  endtask

  task automatic settle();
    repeat (2 * OM + 8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 ser_data in reset", int'(ser_data), 0);
    chk("R10 ser_clk in reset", int'(ser_clk), 0);
    chk("R10 ser_sync in reset", int'(ser_sync), 0);
  endtask

  task automatic t_trunc();
    clear_rx();
    send(24'h123456, 8, 0, 1, 1);
    get_word("R1 truncate positive", 8, 1, 18);
    send(24'hFF8001, 12, 0, 1, 1);
    get_word("R1 truncate negative", 12, 1, exp_val(24'hFF8001, 12, 0));
    settle();
  endtask

  task automatic t_round();
    clear_rx();
    send(24'h12C000, 8, 1, 1, 1);
    get_word("R2 round up", 8, 1, 19);
    send(24'hFE8000, 8, 1, 1, 1);
    get_word("R2 round negative half", 8, 1, -1);
    send(24'h124000, 8, 1, 1, 1);
    get_word("R2 round down", 8, 1, exp_val(24'h124000, 8, 1));
    settle();
  endtask

  task automatic t_sat();
    clear_rx();
    send(24'h7FF000, 8, 1, 1, 1);
    get_word("R3 saturate w8", 8, 1, 127);
    send(24'h600000, 2, 1, 1, 1);
    get_word("R3 saturate w2", 2, 1, 1);
    settle();
  endtask

  task automatic t_order();
    clear_rx();
    send(24'h5A0000, 8, 0, 0, 1);
    get_word("R5 lsb first", 8, 0, 90);
    send(24'hC30000, 8, 0, 1, 1);
    get_word("R5 msb first", 8, 1, exp_val(24'hC30000, 8, 0));
    settle();
  endtask

  task automatic t_width();
    clear_rx();
    send(24'hABCDEF, 16, 0, 1, 1);
    get_word("R4 width max", 16, 1, -21555);
    send(24'hABCDEF, 0, 0, 1, 1);
    get_word("R4 width zero", 0, 1, -21555);
    send(24'h3ABCDE, 31, 1, 0, 1);
    get_word("R4 width too big", 31, 0, exp_val(24'h3ABCDE, 31, 1));
    send(24'h400000, 2, 0, 1, 1);
    get_word("R4 width min", 2, 1, 1);
    settle();
  endtask

  task automatic t_timing();
    clear_rx();
    send(24'h550000, 8, 0, 1, 1);
    // send returns one negedge after the sampling edge
    chk("R8 no sync before load", int'(ser_sync), 0);
    @(negedge clk);
    chk("R8 sync after load", int'(ser_sync), 1);
    chk("R6 clk low first half", int'(ser_clk), 0);
    @(negedge clk);
    chk("R6 sync second half", int'(ser_sync), 1);
    chk("R6 clk high second half", int'(ser_clk), 1);
    @(negedge clk);
    chk("R6 sync ends", int'(ser_sync), 0);
    chk("R6 clk low next bit", int'(ser_clk), 0);
    settle();
    chk("R7 clk low when idle", int'(ser_clk), 0);
    clear_rx();
  endtask

  task automatic t_gate();
    int highs, syncs;
    clear_rx();
    highs = 0; syncs = 0;
    send(24'h7F0000, 8, 0, 1, 0);
    repeat (2 * 8 + 6) begin
      @(negedge clk);
      highs += int'(ser_clk);
      syncs += int'(ser_sync);
    end
    chk("R7 no clock when gated", highs, 0);
    chk("R7 sync still sent", syncs, 2);
    settle();
  endtask

  task automatic t_back();
    int d;
    clear_rx();
    send(24'h110000, 8, 0, 1, 1);
    repeat (3) @(negedge clk);
    send(24'hEE0000, 8, 0, 1, 1);
    get_word("R8 first word", 8, 1, 17);
    get_word("R8 held word", 8, 1, -18);
    d = (sync_at.size() >= 2) ? sync_at[1] - sync_at[0] : -1;
    chk("R8 no gap", d, 16);
    settle();
  endtask

  task automatic t_replace();
    clear_rx();
    send(24'h210000, 8, 0, 1, 1);
    repeat (2) @(negedge clk);
    send(24'h320000, 8, 0, 1, 1);
    send(24'h430000, 8, 0, 1, 1);
    get_word("R9 current word", 8, 1, 33);
    get_word("R9 newer replaces held", 8, 1, 67);
    settle();
    chk("R9 older never sent", rx_bit.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_trunc();
    t_round();
    t_sat();
    t_order();
    t_width();
    t_timing();
    t_gate();
    t_back();
    t_replace();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule